// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block gathers eight level-sensitive interrupt request lines, decides which of them may interrupt the processor, and raises one interrupt output when at least one may. It holds three 8-bit vectors: the latched requests, a mask that blocks individual lines, and an in-service vector that records which levels the processor is handling. A priority resolver orders the eight levels in a circle. The level named as lowest can be moved, and the level after it in circular order is then the highest.

The processor answers the interrupt with a one-cycle acknowledge strobe. One cycle later the block reports the acknowledged level number with a valid pulse. Software drives a command port to finish service routines in several ways. It can clear the highest-priority in-service level or a named level. It can move the lowest-priority point, with or without clearing a named in-service level. It can also set and clear mask bits, switch to an automatic end-of-service mode, and switch to a special mask mode. In that mode, levels of lower priority may interrupt a routine that is still running.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Opcode 0x5 sets and opcode 0x6 clears mask bit `cmd_lvl_i`. When mask bit n is set, request line n never raises `int_o` and is never acknowledged.
- R2: After reset, level 0 has the highest priority and level 7 the lowest. When `inta_i` is high and `int_o` is high at a clock edge, then in the next cycle `ack_vld_o` is 1 for one cycle and `ack_lvl_o` holds the highest-priority forwarded level. When `int_o` is low, `inta_i` gives no `ack_vld_o`.
- R3: Outside special mask mode, a request is forwarded only if its priority is strictly higher than that of every in-service level. An acknowledge sets the in-service bit of the acknowledged level.
- R4: Opcode 0x1 (general end of service) clears the in-service bit of highest current priority. This is not necessarily the level acknowledged most recently.
- R5: Opcode 0x2 clears exactly in-service bit `cmd_lvl_i`.
- R6: Opcode 0x3 makes `cmd_lvl_i` the lowest priority. Level `cmd_lvl_i`+1 (mod 8) becomes the highest.
- R7: Opcode 0x4 clears in-service bit `cmd_lvl_i` and also makes that level the lowest priority, in one command.
- R8: Opcode 0x7 turns automatic end-of-service mode on and opcode 0x8 turns it off. While the mode is on, an acknowledge leaves the in-service vector unchanged.
- R9: Opcode 0x9 turns special mask mode on and it stays on until opcode 0xA. While it is on, in-service bits block no level, and only mask bits exclude a level.
- R10: Opcodes 0x0 and 0xB to 0xF change no state.
- R11: Reset clears the mask, in-service and request vectors, and turns both modes off. `int_o` and `ack_vld_o` are 0 during and after reset until a request arrives.
- R12: An acknowledge clears the request latch of the acknowledged level in the same edge. A line that is still high is latched again at the following clock.
- R13: A priority change made while a level is in service does not let any level preempt it. A request whose new priority is lower than the in-service level waits until that bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 8 | Level-sensitive request lines, bit n is level n |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 4 | Command opcode |
| cmd_lvl_i | input | 3 | Level operand of the command |
| inta_i | input | 1 | Acknowledge strobe from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| ack_vld_o | output | 1 | Acknowledged level is valid (one cycle) |
| ack_lvl_o | output | 3 | Number of the acknowledged level |

## Verification
Two simultaneous requests on distinct levels show whether the resolver takes the highest-priority level rather than the lowest-numbered or the most recent one. Stacked acknowledges followed by a late request between two in-service levels show whether the general end of service clears the right bit: only the correct choice lets that request through. Rotated orders check that the highest level follows the lowest point around the circle. A priority change made during service checks that it does not preempt. Masked lines, lines still held high across an acknowledge, and undefined opcodes aimed at an in-service level show whether each one leaves the interrupt output as the requirements demand.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [3:0] {
        OP_EOI_TOP   = 4'h1,
        OP_EOI_LVL   = 4'h2,
        OP_SET_LOW   = 4'h3,
        OP_ROT_EOI   = 4'h4,
        OP_MASK_SET  = 4'h5,
        OP_MASK_CLR  = 4'h6,
        OP_AUTO_ON   = 4'h7,
        OP_AUTO_OFF  = 4'h8,
        OP_SPMASK_ON = 4'h9,
        OP_SPMASK_OFF= 4'hA
    } cmd_op_e;

    typedef struct packed {
        logic eoi_top;
        logic eoi_lvl;
        logic set_low;
        logic mask_set;
        logic mask_clr;
        logic auto_on;
        logic auto_off;
        logic spmask_on;
        logic spmask_off;
    } cmd_act_t;

endpackage

// File: rtl/prio_irq_gate.sv
// Decides which unmasked requests may reach the processor: in nested
// operation only those ranked strictly above every in-service level.
module prio_irq_gate #(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] elig_i,
    input  logic [N_IRQ-1:0] isr_i,
    input  logic [LW-1:0]    hi_i,
    input  logic             spmask_i,
    output logic [N_IRQ-1:0] fwd_o
);

    logic          isr_any;
    logic [LW-1:0] isr_rank;
    logic [LW-1:0] lvl_idx;
    logic [LW-1:0] lvl_rank;

    always_comb begin
        isr_any  = 1'b0;
        isr_rank = '0;
        lvl_idx  = '0;
        for (int k = 0; k < N_IRQ; k++) begin
            lvl_idx = LW'(hi_i + LW'(k));
            if (!isr_any && isr_i[lvl_idx]) begin
                isr_any  = 1'b1;
                isr_rank = LW'(k);
            end
        end
    end

    always_comb begin
        fwd_o    = '0;
        lvl_rank = '0;
        for (int l = 0; l < N_IRQ; l++) begin
            lvl_rank = LW'(LW'(l) - hi_i);
            fwd_o[l] = elig_i[l] & (spmask_i | !isr_any | (lvl_rank < isr_rank));
        end
    end

endmodule

// File: rtl/prio_irq_resolver.sv
// Circular priority search: starting at the highest level, returns the
// first set bit of the vector.
module prio_irq_resolver #(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] vec_i,
    input  logic [LW-1:0]    hi_i,
    output logic             found_o,
    output logic [LW-1:0]    lvl_o
);

    logic [LW-1:0] idx;

    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        idx     = '0;
        for (int k = 0; k < N_IRQ; k++) begin
            idx = LW'(hi_i + LW'(k));
            if (!found_o && vec_i[idx]) begin
                found_o = 1'b1;
                lvl_o   = idx;
            end
        end
    end

endmodule

// File: rtl/prio_irq_cmd_dec.sv
// Turns one command strobe into action flags; unknown opcodes yield none.
module prio_irq_cmd_dec
    import prio_irq_pkg::*;
#(
    parameter int unsigned OP_W = 4
) (
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    output cmd_act_t        act_o
);

    always_comb begin
        act_o = '0;
        if (valid_i) begin
            case (op_i)
                OP_EOI_TOP:    act_o.eoi_top    = 1'b1;
                OP_EOI_LVL:    act_o.eoi_lvl    = 1'b1;
                OP_SET_LOW:    act_o.set_low    = 1'b1;
                OP_ROT_EOI: begin
                    act_o.eoi_lvl = 1'b1;
                    act_o.set_low = 1'b1;
                end
                OP_MASK_SET:   act_o.mask_set   = 1'b1;
                OP_MASK_CLR:   act_o.mask_clr   = 1'b1;
                OP_AUTO_ON:    act_o.auto_on    = 1'b1;
                OP_AUTO_OFF:   act_o.auto_off   = 1'b1;
                OP_SPMASK_ON:  act_o.spmask_on  = 1'b1;
                OP_SPMASK_OFF: act_o.spmask_off = 1'b1;
                default:       act_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ = 8,
    parameter int unsigned OP_W  = 4,
    localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic             cmd_valid_i,
    input  logic [OP_W-1:0]  cmd_op_i,
    input  logic [LVL_W-1:0] cmd_lvl_i,
    input  logic             inta_i,
    output logic             int_o,
    output logic             ack_vld_o,
    output logic [LVL_W-1:0] ack_lvl_o
);

    typedef struct packed {
        logic [N_IRQ-1:0] req;
        logic [N_IRQ-1:0] imr;
        logic [N_IRQ-1:0] isr;
        logic [LVL_W-1:0] low;
        logic             autoeoi;
        logic             spmask;
        logic             ack_vld;
        logic [LVL_W-1:0] ack_lvl;
    } state_t;

    state_t st_d, st_q;

    cmd_act_t         act;
    logic [LVL_W-1:0] hi;
    logic [N_IRQ-1:0] elig;
    logic [N_IRQ-1:0] fwd;
    logic             win_found;
    logic [LVL_W-1:0] win_lvl;
    logic             top_found;
    logic [LVL_W-1:0] top_lvl;
    logic             take;

    assign hi   = LVL_W'(st_q.low + 1'b1);
    assign elig = st_q.req & ~st_q.imr;

    prio_irq_cmd_dec #(.OP_W(OP_W)) u_dec (
        .valid_i (cmd_valid_i),
        .op_i    (cmd_op_i),
        .act_o   (act)
    );

    prio_irq_gate #(.N_IRQ(N_IRQ)) u_gate (
        .elig_i   (elig),
        .isr_i    (st_q.isr),
        .hi_i     (hi),
        .spmask_i (st_q.spmask),
        .fwd_o    (fwd)
    );

    prio_irq_resolver #(.N_IRQ(N_IRQ)) u_win (
        .vec_i   (fwd),
        .hi_i    (hi),
        .found_o (win_found),
        .lvl_o   (win_lvl)
    );

    prio_irq_resolver #(.N_IRQ(N_IRQ)) u_top (
        .vec_i   (st_q.isr),
        .hi_i    (hi),
        .found_o (top_found),
        .lvl_o   (top_lvl)
    );

    assign take = inta_i & win_found;

    always_comb begin
        st_d = st_q;

        // acknowledge path
        st_d.ack_vld = take;
        st_d.req     = irq_req_i;
        if (take) begin
            st_d.ack_lvl      = win_lvl;
            st_d.req[win_lvl] = 1'b0;
            if (!st_q.autoeoi) begin
                st_d.isr[win_lvl] = 1'b1;
            end
        end

        // command path, applied after the acknowledge update
        if (act.eoi_top && top_found) begin
            st_d.isr[top_lvl] = 1'b0;
        end
        if (act.eoi_lvl) begin
            st_d.isr[cmd_lvl_i] = 1'b0;
        end
        if (act.set_low) begin
            st_d.low = cmd_lvl_i;
        end
        if (act.mask_set) begin
            st_d.imr[cmd_lvl_i] = 1'b1;
        end
        if (act.mask_clr) begin
            st_d.imr[cmd_lvl_i] = 1'b0;
        end
        if (act.auto_on) begin
            st_d.autoeoi = 1'b1;
        end
        if (act.auto_off) begin
            st_d.autoeoi = 1'b0;
        end
        if (act.spmask_on) begin
            st_d.spmask = 1'b1;
        end
        if (act.spmask_off) begin
            st_d.spmask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.low     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o     = win_found;
    assign ack_vld_o = st_q.ack_vld;
    assign ack_lvl_o = st_q.ack_lvl;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ = 8,
    parameter int unsigned OP_W  = 4,
    localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid_i,
    input logic [OP_W-1:0]  cmd_op_i,
    input logic [LVL_W-1:0] cmd_lvl_i,
    input logic             inta_i,
    input logic             int_o,
    input logic             ack_vld_o,
    input logic [LVL_W-1:0] ack_lvl_o,
    input logic [N_IRQ-1:0] req_q,
    input logic [N_IRQ-1:0] imr_q,
    input logic [N_IRQ-1:0] isr_q,
    input logic [LVL_W-1:0] low_q,
    input logic             auto_q,
    input logic             spmask_q
);

    logic [N_IRQ-1:0] prev_isr;
    logic             undef_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_isr <= '0;
        else        prev_isr <= isr_q;
    end

    assign undef_op = (cmd_op_i == '0) || (cmd_op_i > OP_W'(OP_SPMASK_OFF));

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((req_q & ~imr_q) != '0)); // R1

    AST_ACK_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && int_o) |=> ack_vld_o); // R2

    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !int_o) |=> !ack_vld_o); // R2

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && int_o && !auto_q && !cmd_valid_i) |=> isr_q[ack_lvl_o]); // R3

    AST_NESTED_NOT_REACK: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && int_o && !spmask_q) |=> !prev_isr[ack_lvl_o]); // R3

    AST_LVL_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == OP_W'(OP_EOI_LVL))) |=> !isr_q[$past(cmd_lvl_i)]); // R5

    AST_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == OP_W'(OP_SET_LOW))) |=> (low_q == $past(cmd_lvl_i))); // R6

    AST_ROT_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == OP_W'(OP_ROT_EOI)))
        |=> ((low_q == $past(cmd_lvl_i)) && !isr_q[$past(cmd_lvl_i)])); // R7

    AST_AUTO_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && inta_i && !cmd_valid_i) |=> ($countones(isr_q) <= $countones(prev_isr))); // R8

    AST_SPMASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spmask_q && !(cmd_valid_i && (cmd_op_i == OP_W'(OP_SPMASK_OFF)))) |=> spmask_q); // R9

    AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && undef_op && !inta_i)
        |=> ($stable(imr_q) && $stable(isr_q) && $stable(low_q)
             && $stable(auto_q) && $stable(spmask_q))); // R10

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ), .OP_W(OP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_lvl_i   (cmd_lvl_i),
    .inta_i      (inta_i),
    .int_o       (int_o),
    .ack_vld_o   (ack_vld_o),
    .ack_lvl_o   (ack_lvl_o),
    .req_q       (st_q.req),
    .imr_q       (st_q.imr),
    .isr_q       (st_q.isr),
    .low_q       (st_q.low),
    .auto_q      (st_q.autoeoi),
    .spmask_q    (st_q.spmask)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [2:0] cmd_lvl = '0;
    logic       inta = 1'b0;
    logic       int_o;
    logic       ack_vld_o;
    logic [2:0] ack_lvl_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (irq),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_lvl_i   (cmd_lvl),
        .inta_i      (inta),
        .int_o       (int_o),
        .ack_vld_o   (ack_vld_o),
        .ack_lvl_o   (ack_lvl_o)
    );

    // ---------------- behavioural reference ----------------
    bit [7:0] m_req, m_imr, m_isr;
    int       m_low;
    bit       m_auto, m_spm, m_ackv;
    int       m_ackl;

    function automatic int rank_of(int l);
        return (l - (m_low + 1) + 16) % 8;
    endfunction

    function automatic int isr_top();
        int best = -1;
        for (int l = 0; l < 8; l++)
            if (m_isr[l] && (best < 0 || rank_of(l) < rank_of(best))) best = l;
        return best;
    endfunction

    function automatic int model_win();
        int best = -1;
        int lim  = 8;
        int t    = isr_top();
        if (t >= 0) lim = rank_of(t);
        for (int l = 0; l < 8; l++)
            if (m_req[l] && !m_imr[l] && (m_spm || rank_of(l) < lim)
                && (best < 0 || rank_of(l) < rank_of(best))) best = l;
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = 0; m_imr = 0; m_isr = 0; m_low = 7;
            m_auto = 0; m_spm = 0; m_ackv = 0; m_ackl = 0;
        end else begin
            int w, t;
            bit [7:0] nreq, nisr, nimr;
            int nlow;
            bit nauto, nspm;
            w = model_win();
            t = isr_top();
            nreq = irq; nisr = m_isr; nimr = m_imr; nlow = m_low;
            nauto = m_auto; nspm = m_spm;
            m_ackv = inta && (w >= 0);
            if (m_ackv) begin
                m_ackl = w;
                nreq[w] = 1'b0;
                if (!m_auto) nisr[w] = 1'b1;
            end
            if (cmd_valid) begin
                case (cmd_op)
                    4'h1: if (t >= 0) nisr[t] = 1'b0;
                    4'h2: nisr[cmd_lvl] = 1'b0;
                    4'h3: nlow = cmd_lvl;
                    4'h4: begin nisr[cmd_lvl] = 1'b0; nlow = cmd_lvl; end
                    4'h5: nimr[cmd_lvl] = 1'b1;
                    4'h6: nimr[cmd_lvl] = 1'b0;
                    4'h7: nauto = 1'b1;
                    4'h8: nauto = 1'b0;
                    4'h9: nspm = 1'b1;
                    4'hA: nspm = 1'b0;
                    default: ;
                endcase
            end
            m_req = nreq; m_isr = nisr; m_imr = nimr; m_low = nlow;
            m_auto = nauto; m_spm = nspm;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference (R2, R3 and all commands)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int_o == (model_win() >= 0), "R3 model int_o", int_o, model_win() >= 0);
            check(ack_vld_o == m_ackv, "R2 model ack_vld_o", ack_vld_o, m_ackv);
            if (m_ackv) check(ack_lvl_o == m_ackl[2:0], "R2 model ack_lvl_o", ack_lvl_o, m_ackl);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive_irq(logic [7:0] v);
        irq = v;
        tick();
    endtask

    task automatic cmd(logic [3:0] op, logic [2:0] lvl);
        cmd_valid = 1'b1; cmd_op = op; cmd_lvl = lvl;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic ack(int exp, string tag);
        inta = 1'b1;
        tick();
        inta = 1'b0;
        check(ack_vld_o && ack_lvl_o == exp[2:0], tag, ack_vld_o ? int'(ack_lvl_o) : -1, exp);
    endtask

    task automatic expect_int(bit e, string tag);
        check(int_o == e, tag, int_o, e);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        expect_int(0, "R11 int_o in reset");
        check(ack_vld_o == 0, "R11 ack_vld_o in reset", ack_vld_o, 0);
        rst_n = 1'b1;
        tick();
        expect_int(0, "R11 int_o after reset");

        // R2: two requests, level 3 beats level 5 with reset order
        drive_irq(8'b0010_1000);
        expect_int(1, "R2 int raised");
        ack(3, "R2 highest of 3 and 5");
        irq = 8'b0010_0000;
        expect_int(0, "R3 level 5 held off by 3 in service");
        drive_irq(8'b0010_0010);
        expect_int(1, "R3 level 1 above in-service 3");
        ack(1, "R3 nested ack of 1");
        irq = 8'b0010_0000;
        tick();
        // R4: general end clears 1 (highest), not 3
        cmd(4'h1, 3'd0);
        drive_irq(8'b0010_0100);
        expect_int(1, "R4 level 2 forwarded once 1 cleared");
        drive_irq(8'b0010_0000);
        expect_int(0, "R4 level 3 still in service");
        // R5: named end clears 3
        cmd(4'h2, 3'd3);
        expect_int(1, "R5 level 5 released");
        ack(5, "R5 ack of 5");
        irq = 8'h00;
        cmd(4'h2, 3'd5);

        // R1: mask
        cmd(4'h5, 3'd4);
        drive_irq(8'b0001_0000);
        tick();
        expect_int(0, "R1 masked line silent");
        inta = 1'b1; tick(); inta = 1'b0;
        check(ack_vld_o == 0, "R1 masked line not acknowledged", ack_vld_o, 0);
        cmd(4'h6, 3'd4);
        expect_int(1, "R1 unmasked line raises int");
        ack(4, "R1 ack after unmask");
        irq = 8'h00;
        cmd(4'h2, 3'd4);

        // R6: level 4 lowest, 5 highest: 6 beats 2
        cmd(4'h3, 3'd4);
        drive_irq(8'b0100_0100);
        ack(6, "R6 rotated order picks 6");
        irq = 8'b0000_0100;
        cmd(4'h2, 3'd6);
        ack(2, "R6 then 2");
        irq = 8'h00;
        cmd(4'h2, 3'd2);

        // R7: rotate on named end
        drive_irq(8'b1000_0000);
        ack(7, "R7 ack of 7");
        irq = 8'h00;
        cmd(4'h4, 3'd7);
        drive_irq(8'b0010_0001);
        ack(0, "R7 level 0 highest after rotate to 7");
        irq = 8'h00;
        cmd(4'h2, 3'd0);
        tick();

        // R13: priority change while 3 in service
        drive_irq(8'b0000_1000);
        ack(3, "R13 ack of 3");
        irq = 8'h00;
        cmd(4'h3, 3'd2);
        drive_irq(8'b0000_0010);
        expect_int(0, "R13 no preempt after priority change");
        cmd(4'h2, 3'd3);
        expect_int(1, "R13 released once 3 cleared");
        ack(1, "R13 ack of 1");
        irq = 8'h00;
        cmd(4'h2, 3'd1);
        cmd(4'h3, 3'd7);

        // R8 and R12: automatic end of service, line held across ack
        cmd(4'h7, 3'd0);
        drive_irq(8'b0100_0000);
        ack(6, "R8 ack of 6 in auto mode");
        expect_int(0, "R12 latch cleared on ack");
        tick();
        expect_int(1, "R12 held line relatched");
        irq = 8'h00;
        tick();
        drive_irq(8'b1000_0000);
        expect_int(1, "R8 no in-service bit left behind");
        ack(7, "R8 ack of 7");
        irq = 8'h00;
        cmd(4'h8, 3'd0);

        // R9: special mask mode
        drive_irq(8'b0000_0100);
        ack(2, "R9 ack of 2");
        irq = 8'b0010_0000;
        tick();
        expect_int(0, "R9 5 blocked before mode");
        cmd(4'h5, 3'd2);
        cmd(4'h9, 3'd0);
        expect_int(1, "R9 5 enabled in special mask mode");
        ack(5, "R9 ack of 5 below in-service 2");
        drive_irq(8'b0000_0100);
        tick();
        expect_int(0, "R9 in-service 2 excluded by its mask bit");
        irq = 8'h00;
        cmd(4'hA, 3'd0);
        cmd(4'h2, 3'd5);
        cmd(4'h2, 3'd2);
        cmd(4'h6, 3'd2);

        // R10: undefined opcodes aimed at in-service level 3
        drive_irq(8'b0000_1000);
        ack(3, "R10 ack of 3");
        irq = 8'h00;
        cmd(4'h0, 3'd3);
        cmd(4'hB, 3'd3);
        cmd(4'hC, 3'd3);
        cmd(4'hD, 3'd3);
        cmd(4'hE, 3'd3);
        cmd(4'hF, 3'd3);
        drive_irq(8'b0010_0000);
        expect_int(0, "R10 in-service bit untouched");
        cmd(4'h2, 3'd3);
        expect_int(1, "R10 order and mask untouched");
        ack(5, "R10 ack of 5");
        irq = 8'h00;
        cmd(4'h2, 3'd5);
        repeat (3) tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule